// File: doc/BRIEF.md
# Transmit PLL Lock Qualifier

A transmit PLL can report itself locked even while it is held in powerdown, so its raw lock flag cannot be handed straight to reset sequencing. This block sits in the calibration clock domain. It turns that raw flag into a qualified lock status that downstream reset logic, and any other logic that needs to know whether the PLL is locked, can rely on.

While powerdown is active, the qualified output is cleared at once. Once powerdown is released, the block waits out a worst-case lock interval. The interval is given as a clock rate in kHz and a time in microseconds, and is turned into a cycle count when the design is elaborated. Only after that interval does the output follow the raw flag, through a two-flop synchroniser. A later drop of the raw flag shows up at the output within the synchroniser latency and does not restart the wait.

Top module: `txpll_lock_qualifier`

## Requirements
- R1: While `pwrdn_i` is 1, `lock_ok_o` is 0. It falls without waiting for a clock edge, whatever `lock_raw_i` is doing.
- R2: A release of `pwrdn_i` (1 to 0) reaches the internal logic through two calibration clock flops. The internal powerdown is therefore seen low from the second rising edge after the release.
- R3: After the internal powerdown goes low, `lock_ok_o` stays 0 for `HOLD` rising edges. With `lock_raw_i` held at 1, `lock_ok_o` becomes 1 right after rising edge 2+`HOLD`, counted from the release of `pwrdn_i`.
- R4: Any assertion of `pwrdn_i`, even for one cycle, clears the hold-off count. The full `HOLD` interval then starts again from the next release.
- R5: Once qualified, a fall of `lock_raw_i` gives `lock_ok_o` = 0 after the second rising edge and not before.
- R6: Once qualified, a rise of `lock_raw_i` gives `lock_ok_o` = 1 after the second rising edge, without a new hold-off.
- R7: Activity on `lock_raw_i` during the hold-off interval has no effect: `lock_ok_o` stays 0 throughout.
- R8: `HOLD` = `CLK_KHZ` * `HOLD_US` / 1000 (at least 1). The defaults of 125000 kHz and 100 µs give 12500 cycles, and the counter width is derived from `HOLD`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Calibration clock, 10 to 125 MHz |
| pwrdn_i | input | 1 | PLL powerdown, active high, asynchronous |
| lock_raw_i | input | 1 | Unqualified lock flag from the PLL, asynchronous |
| lock_ok_o | output | 1 | Qualified lock status for reset and user logic |

## Verification
The results fall due at different times. The powerdown clear lands within a nanosecond of the stimulus, with no clock edge involved. The qualified rise lands exactly 2+`HOLD` rising edges after the release. A raw-flag change after qualification reaches the output exactly two edges later. The bench drives every input on a falling edge and samples on a falling edge, so the value it reads after k falling edges reflects exactly k rising edges. Each latency is probed one edge early, where the old value must still hold, and on the due edge, where the new value must appear.

// File: rtl/txpll_lq_pkg.sv
package txpll_lq_pkg;

  // Cycles needed to span hold_us microseconds at clk_khz kHz; never below 1.
  function automatic int hold_cycles(input int clk_khz, input int hold_us);
    longint prod;
    prod = longint'(clk_khz) * longint'(hold_us) / 64'sd1000;
    if (prod < 1) prod = 1;
    return int'(prod);
  endfunction

  // Bits needed to hold values 0 .. n.
  function automatic int cnt_width(input int n);
    return (n < 1) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/txpll_pd_release.sv
module txpll_pd_release #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic pwrdn_i,
  output logic pd_int_o
);
  logic [STAGES-1:0] pd_q;

  always_ff @(posedge clk_i or posedge pwrdn_i) begin
    if (pwrdn_i) pd_q <= '1;
    else         pd_q <= {pd_q[STAGES-2:0], 1'b0};
  end

  assign pd_int_o = pd_q[STAGES-1];
endmodule

// File: rtl/txpll_lock_sync.sv
module txpll_lock_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic clr_i,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] s_q;

  always_ff @(posedge clk_i or posedge clr_i) begin
    if (clr_i) s_q <= '0;
    else       s_q <= {s_q[STAGES-2:0], d_i};
  end

  assign q_o = s_q[STAGES-1];
endmodule

// File: rtl/txpll_holdoff_timer.sv
module txpll_holdoff_timer #(
  parameter int HOLD = 12500,
  parameter int CW   = 14
) (
  input  logic          clk_i,
  input  logic          clr_i,
  output logic [CW-1:0] cnt_o,
  output logic          done_o
);
  localparam logic [CW-1:0] LAST = CW'(HOLD - 1);

  logic [CW-1:0] cnt_q;
  logic          done_q;

  always_ff @(posedge clk_i or posedge clr_i) begin
    if (clr_i) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (!done_q) begin
      if (cnt_q == LAST) done_q <= 1'b1;
      else               cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign cnt_o  = cnt_q;
  assign done_o = done_q;
endmodule

// File: rtl/txpll_lock_qualifier.sv
module txpll_lock_qualifier #(
  parameter int CLK_KHZ  = 125000,
  parameter int HOLD_US  = 100,
  parameter int PD_STG   = 2,
  parameter int LOCK_STG = 2
) (
  input  logic clk_i,
  input  logic pwrdn_i,
  input  logic lock_raw_i,
  output logic lock_ok_o
);
  localparam int HOLD  = txpll_lq_pkg::hold_cycles(CLK_KHZ, HOLD_US);
  localparam int CNT_W = txpll_lq_pkg::cnt_width(HOLD);

  // Named internal events, exposed for the bound checker.
  logic             pd_int;
  logic             lock_s;
  logic             timer_done;
  logic [CNT_W-1:0] hold_cnt;

  txpll_pd_release #(.STAGES(PD_STG)) u_pd_rel (
    .clk_i    (clk_i),
    .pwrdn_i  (pwrdn_i),
    .pd_int_o (pd_int)
  );

  txpll_lock_sync #(.STAGES(LOCK_STG)) u_lock_sync (
    .clk_i (clk_i),
    .clr_i (pd_int),
    .d_i   (lock_raw_i),
    .q_o   (lock_s)
  );

  txpll_holdoff_timer #(.HOLD(HOLD), .CW(CNT_W)) u_timer (
    .clk_i  (clk_i),
    .clr_i  (pd_int),
    .cnt_o  (hold_cnt),
    .done_o (timer_done)
  );

  assign lock_ok_o = timer_done & lock_s;
endmodule

// File: rtl/txpll_lock_qualifier_chk.sv
module txpll_lock_qualifier_chk #(
  parameter int HOLD = 12500,
  parameter int CW   = 14
) (
  input logic          clk_i,
  input logic          pwrdn_i,
  input logic          lock_raw_i,
  input logic          lock_ok_o,
  input logic          pd_int,
  input logic          timer_done,
  input logic [CW-1:0] hold_cnt
);
  // Independent count of edges seen since internal powerdown release (saturating).
  int unsigned since_rel;
  always_ff @(posedge clk_i or posedge pd_int) begin
    if (pd_int) since_rel <= 0;
    else if (since_rel < HOLD) since_rel <= since_rel + 1;
  end

  assert_pd_forces_low_R1: assert property (@(posedge clk_i)
    pwrdn_i |-> !lock_ok_o);

  assert_pd_implies_internal_R2: assert property (@(posedge clk_i)
    pwrdn_i |-> pd_int);

  assert_holdoff_respected_R3: assert property (@(posedge clk_i) disable iff (pd_int)
    lock_ok_o |-> (since_rel >= HOLD));

  assert_count_in_range_R8: assert property (@(posedge clk_i) disable iff (pd_int)
    hold_cnt <= CW'(HOLD - 1));

  assert_done_sticky_R4: assert property (@(posedge clk_i) disable iff (pd_int)
    timer_done |=> timer_done);

  assert_drop_follows_R5: assert property (@(posedge clk_i) disable iff (pd_int)
    (!lock_raw_i && !$past(lock_raw_i)) |=> !lock_ok_o);

  assert_rise_follows_R6: assert property (@(posedge clk_i) disable iff (pd_int)
    (timer_done && $past(timer_done) && lock_raw_i && $past(lock_raw_i)) |=> lock_ok_o);
endmodule

bind txpll_lock_qualifier txpll_lock_qualifier_chk #(.HOLD(HOLD), .CW(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .pwrdn_i    (pwrdn_i),
  .lock_raw_i (lock_raw_i),
  .lock_ok_o  (lock_ok_o),
  .pd_int     (pd_int),
  .timer_done (timer_done),
  .hold_cnt   (hold_cnt)
);

// File: tb/txpll_lock_qualifier_bench.sv
`timescale 1ns/1ps
module txpll_lock_qualifier_bench;
  localparam int KHZ = 125000;
  localparam int US  = 1;
  // R8 restated: 125 MHz for 1 us is 125 cycles.
  localparam int HOLD_EXP = (KHZ / 1000) * US;

  logic clk = 1'b0;
  logic pwrdn;
  logic raw;
  logic ok;
  int   n_chk = 0;
  int   n_bad = 0;
  bit   finished = 1'b0;

  always #4 clk = ~clk;

  txpll_lock_qualifier #(.CLK_KHZ(KHZ), .HOLD_US(US)) u_txpll_lock_qualifier (
    .clk_i      (clk),
    .pwrdn_i    (pwrdn),
    .lock_raw_i (raw),
    .lock_ok_o  (ok)
  );

  task automatic chk(input logic exp, input string tag);
    n_chk++;
    if (ok !== exp) begin
      n_bad++;
      $display("FAIL %s: lock_ok_o=%b expected %b at %0t", tag, ok, exp, $time);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    pwrdn = 1'b1; raw = 1'b0;
    edges(3);
    chk(1'b0, "R1 reset state");
    raw = 1'b1;
    edges(4);
    chk(1'b0, "R1 raw high during powerdown");
  endtask

  task automatic t_holdoff();
    pwrdn = 1'b0;
    edges(2);
    chk(1'b0, "R2 just after release");
    edges(HOLD_EXP - 1);
    chk(1'b0, "R3/R8 one edge before hold-off end");
    edges(1);
    chk(1'b1, "R3/R8 qualified at edge 2+HOLD");
  endtask

  task automatic t_follow();
    raw = 1'b0;
    edges(1);
    chk(1'b1, "R5 drop not yet visible");
    edges(1);
    chk(1'b0, "R5 drop after two edges");
    raw = 1'b1;
    edges(1);
    chk(1'b0, "R6 rise not yet visible");
    edges(1);
    chk(1'b1, "R6 rise after two edges, no new hold-off");
  endtask

  task automatic t_async_pd();
    #2 pwrdn = 1'b1;
    #1 chk(1'b0, "R1 immediate clear on powerdown");
    edges(3);
    chk(1'b0, "R1 held low in powerdown");
  endtask

  task automatic t_restart();
    pwrdn = 1'b0;
    edges(HOLD_EXP / 2);
    pwrdn = 1'b1;
    edges(1);
    chk(1'b0, "R4 pulse mid hold-off");
    pwrdn = 1'b0;
    edges(1 + HOLD_EXP);
    chk(1'b0, "R4 full hold-off restarted");
    edges(1);
    chk(1'b1, "R4 qualified after restarted interval");
  endtask

  task automatic t_ignore();
    pwrdn = 1'b1; raw = 1'b0;
    edges(2);
    pwrdn = 1'b0;
    for (int i = 0; i < 8; i++) begin
      raw = ~raw;
      edges(10);
      chk(1'b0, "R7 raw toggling during hold-off");
    end
    raw = 1'b0;
    edges(HOLD_EXP);
    chk(1'b0, "R7 raw low at hold-off end");
    raw = 1'b1;
    edges(1);
    chk(1'b0, "R6 late rise not yet visible");
    edges(1);
    chk(1'b1, "R6 late rise after two edges");
  endtask

  initial begin
    t_reset();
    t_holdoff();
    t_follow();
    t_async_pd();
    t_restart();
    t_ignore();
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule